// File: doc/BRIEF.md
# Flash Command Controller with Unlock Key

This block sits between a CPU-side register bus and a small behavioural flash array. It sequences the operations that change the array: byte programming, sector erase and a one-way hard lock. Software first writes an unlock key to a key register. It then writes a control register that holds a 4-bit operation code and a start bit. Erase and lock only begin when the start bit is written. Byte programming and byte reads do not use the start bit. They go straight through the memory port once programming is selected and the key is present.

A sector erase runs for a set number of clocks. If an interrupt request arrives while the erase is running, the erase stops, the sector is flagged as suspect, and a read-only status bit reports the failure. When any operation finishes, the key is wiped, so every operation needs a fresh key write. Accesses to a sector that is being erased, and any access during a lock, are held off through a busy output. Once the lock has completed, the block refuses all further program, erase and lock requests until reset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Operation codes in control bits 7:4 are 0101 (program), 1010 (erase) and 0110 (lock). A start request with any other code, including 0101, leaves the start bit at 0.
- R2: The control register reads {code[7:4], status[3], 2'b00, start[0]}. Bit 3 cannot be changed by a write. Writes to the control register are ignored while the start bit is 1.
- R3: Writing control bit 0 = 1 with code 1010 or 0110 and a valid key sets the start bit. The bit clears by itself after ERASE_CYCLES clocks (erase) or LOCK_CYCLES clocks (lock), counted from the launch edge, or at an abort.
- R4: With code 0101 and a valid key, a memory write stores old AND data at the address. A read returns the byte on mem_rdata one clock after the read request.
- R5: An erase that runs to the end fills every byte of its sector (selected by op_sector at launch) with FFh. It also clears status bit 3 and the sector's suspect flag, and leaves the other sectors untouched.
- R6: An interrupt request sampled while an erase is running ends it at that edge. Status bit 3 becomes 1, the start bit becomes 0, the sector's suspect flag is set, and the sector contents are not filled.
- R7: Launches and byte programs take effect only while the key register holds A5h. Otherwise they are ignored.
- R8: The key register is cleared after every completed byte program, erase end, erase abort and lock end.
- R9: mem_busy is 1 for a read or write to the sector under erase, and for any access during a lock. A busy access does nothing.
- R10: When a lock completes, `locked` becomes 1 and stays 1 until reset. After that, erase, lock and program requests are ignored.
- R11: After reset the control register reads 00h, `locked` is 0, no sector is suspect, and every array byte reads FFh.
- R12: An interrupt request in the final clock of an erase takes priority over completion. The erase counts as failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the key register |
| reg_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Control register readback |
| op_sector | input | log2(SECTORS) | Sector to erase, sampled at launch |
| irq_req | input | 1 | Interrupt request; aborts a running erase |
| mem_rd | input | 1 | Byte read request |
| mem_wr | input | 1 | Byte program request |
| mem_addr | input | log2(SECTORS*SECTOR_BYTES) | Byte address |
| mem_wdata | input | 8 | Program data |
| mem_rdata | output | 8 | Read data, one clock after the request |
| mem_busy | output | 1 | Access stalled by a running erase or lock |
| locked | output | 1 | Hard lock is in force |
| sector_suspect | output | SECTORS | Per-sector flag set by an aborted erase |

## Verification
Erase completion and interrupt abort can happen in the same clock. The bench holds the interrupt request high exactly in the final counting cycle of an erase. It then expects a failed status, a set suspect flag and unfilled contents. A second pairing is a memory access during an erase: one access goes to the sector being erased and must show busy, and one goes to a different sector and must not.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam logic [3:0] OP_PROG  = 4'b0101;
  localparam logic [3:0] OP_ERASE = 4'b1010;
  localparam logic [3:0] OP_LOCK  = 4'b0110;
  localparam logic [7:0] UNLOCK_KEY = 8'hA5;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_LOCK  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fcc_regs.sv
module fcc_regs
  import fcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       locked,
  input  logic       erase_ok,
  input  logic       erase_fail,
  input  logic       lock_done,
  input  logic       prog_done,
  output logic [3:0] op_code,
  output logic       key_ok,
  output logic       launch_erase,
  output logic       launch_lock,
  output logic [7:0] ctrl_rdata
);
  logic [3:0] code_q, code_d;
  logic       start_q, start_d;
  logic       status_q, status_d;
  logic [7:0] key_q, key_d;
  logic       ctrl_wr, key_wr, launch_ok, op_end;

  assign ctrl_wr   = reg_wr && !reg_sel && !start_q;
  assign key_wr    = reg_wr && reg_sel;
  assign key_ok    = (key_q == UNLOCK_KEY);
  assign launch_ok = ctrl_wr && reg_wdata[0] && key_ok && !locked;
  assign launch_erase = launch_ok && (reg_wdata[7:4] == OP_ERASE);
  assign launch_lock  = launch_ok && (reg_wdata[7:4] == OP_LOCK);
  assign op_end    = erase_ok || erase_fail || lock_done;

  always_comb begin
    code_d   = code_q;
    start_d  = start_q;
    status_d = status_q;
    key_d    = key_q;
    if (ctrl_wr) code_d = reg_wdata[7:4];
    if (launch_erase || launch_lock) start_d = 1'b1;
    else if (op_end) start_d = 1'b0;
    if (erase_fail) status_d = 1'b1;
    else if (erase_ok) status_d = 1'b0;
    if (op_end || prog_done) key_d = 8'h00;
    else if (key_wr) key_d = reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= 4'h0;
      start_q  <= 1'b0;
      status_q <= 1'b0;
      key_q    <= 8'h00;
    end else begin
      code_q   <= code_d;
      start_q  <= start_d;
      status_q <= status_d;
      key_q    <= key_d;
    end
  end

  assign op_code    = code_q;
  assign ctrl_rdata = {code_q, status_q, 2'b00, start_q};

  AST_START_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(key_q) == UNLOCK_KEY); // R7
  AST_BAD_CODE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[7:4] != OP_ERASE && reg_wdata[7:4] != OP_LOCK) |=> !start_q); // R1
  AST_KEY_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_end || prog_done) |=> key_q == 8'h00); // R8
  AST_STATUS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !erase_ok && !erase_fail) |=> $stable(status_q)); // R2
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import fcc_pkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int ERASE_CYCLES = 8,
  parameter int LOCK_CYCLES  = 4,
  localparam int SW = $clog2(SECTORS),
  localparam int MAXC = (ERASE_CYCLES > LOCK_CYCLES) ? ERASE_CYCLES : LOCK_CYCLES,
  localparam int CW = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_erase,
  input  logic          launch_lock,
  input  logic [SW-1:0] op_sector,
  input  logic          irq_req,
  output logic          erasing,
  output logic          lock_busy,
  output logic [SW-1:0] erase_sector,
  output logic          erase_ok,
  output logic          erase_fail,
  output logic          lock_done,
  output logic          locked
);
  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] sect_q, sect_d;
  logic          locked_q, locked_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    sect_d     = sect_q;
    locked_d   = locked_q;
    erase_ok   = 1'b0;
    erase_fail = 1'b0;
    lock_done  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (launch_erase) begin
          state_d = SEQ_ERASE;
          sect_d  = op_sector;
        end else if (launch_lock) begin
          state_d = SEQ_LOCK;
        end
      end
      SEQ_ERASE: begin
        cnt_d = cnt_q + 1'b1;
        if (irq_req) begin
          erase_fail = 1'b1;
          state_d    = SEQ_IDLE;
        end else if (cnt_q == CW'(ERASE_CYCLES - 1)) begin
          erase_ok = 1'b1;
          state_d  = SEQ_IDLE;
        end
      end
      SEQ_LOCK: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(LOCK_CYCLES - 1)) begin
          lock_done = 1'b1;
          locked_d  = 1'b1;
          state_d   = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      cnt_q    <= '0;
      sect_q   <= '0;
      locked_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sect_q   <= sect_d;
      locked_q <= locked_d;
    end
  end

  assign erasing      = (state_q == SEQ_ERASE);
  assign lock_busy    = (state_q == SEQ_LOCK);
  assign erase_sector = sect_q;
  assign locked       = locked_q;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q); // R10
  AST_IRQ_ENDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && irq_req) |=> state_q == SEQ_IDLE); // R6
  AST_NO_LAUNCH_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> !launch_erase && !launch_lock); // R10
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 16,
  localparam int DEPTH = SECTORS * SECTOR_BYTES,
  localparam int SW = $clog2(SECTORS),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  input  logic               fill,
  input  logic               mark_bad,
  input  logic [SW-1:0]      tgt_sector,
  output logic [7:0]         rdata,
  output logic [SECTORS-1:0] suspect
);
  logic [7:0]         mem_q [DEPTH];
  logic [7:0]         mem_d [DEPTH];
  logic [7:0]         rdata_q, rdata_d;
  logic [SECTORS-1:0] sus_q, sus_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (fill && SW'(i / SECTOR_BYTES) == tgt_sector) mem_d[i] = 8'hFF;
      else if (wr_en && AW'(i) == addr) mem_d[i] = mem_q[i] & wdata;
    end
    sus_d = sus_q;
    for (int s = 0; s < SECTORS; s++) begin
      if (SW'(s) == tgt_sector) begin
        if (mark_bad) sus_d[s] = 1'b1;
        else if (fill) sus_d[s] = 1'b0;
      end
    end
    rdata_d = rd_en ? mem_q[addr] : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      rdata_q <= 8'h00;
      sus_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      rdata_q <= rdata_d;
      sus_q   <= sus_d;
    end
  end

  assign rdata   = rdata_q;
  assign suspect = sus_q;

  AST_FILL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (fill && !mark_bad) |=> !suspect[tgt_sector]); // R5
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int SECTORS      = 4,
  parameter int SECTOR_BYTES = 16,
  parameter int ERASE_CYCLES = 8,
  parameter int LOCK_CYCLES  = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     reg_wr,
  input  logic                                     reg_sel,
  input  logic [7:0]                               reg_wdata,
  output logic [7:0]                               ctrl_rdata,
  input  logic [$clog2(SECTORS)-1:0]               op_sector,
  input  logic                                     irq_req,
  input  logic                                     mem_rd,
  input  logic                                     mem_wr,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0]  mem_addr,
  input  logic [7:0]                               mem_wdata,
  output logic [7:0]                               mem_rdata,
  output logic                                     mem_busy,
  output logic                                     locked,
  output logic [SECTORS-1:0]                       sector_suspect
);
  localparam int SW = $clog2(SECTORS);
  localparam int OW = $clog2(SECTOR_BYTES);
  localparam int AW = $clog2(SECTORS * SECTOR_BYTES);

  logic [3:0]    op_code;
  logic          key_ok, launch_erase, launch_lock;
  logic          erasing, lock_busy, erase_ok, erase_fail, lock_done;
  logic [SW-1:0] erase_sector, addr_sector;
  logic          rd_go, wr_go;

  assign addr_sector = mem_addr[AW-1:OW];
  assign mem_busy = (mem_rd || mem_wr) &&
                    (lock_busy || (erasing && addr_sector == erase_sector));
  assign rd_go = mem_rd && !mem_busy;
  assign wr_go = mem_wr && !mem_busy && (op_code == OP_PROG) && key_ok && !locked;

  fcc_regs i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .locked(locked), .erase_ok(erase_ok),
    .erase_fail(erase_fail), .lock_done(lock_done), .prog_done(wr_go),
    .op_code(op_code), .key_ok(key_ok), .launch_erase(launch_erase),
    .launch_lock(launch_lock), .ctrl_rdata(ctrl_rdata)
  );

  fcc_seq #(.SECTORS(SECTORS), .ERASE_CYCLES(ERASE_CYCLES), .LOCK_CYCLES(LOCK_CYCLES)) i_seq (
    .clk(clk), .rst_n(rst_n), .launch_erase(launch_erase), .launch_lock(launch_lock),
    .op_sector(op_sector), .irq_req(irq_req), .erasing(erasing), .lock_busy(lock_busy),
    .erase_sector(erase_sector), .erase_ok(erase_ok), .erase_fail(erase_fail),
    .lock_done(lock_done), .locked(locked)
  );

  fcc_array #(.SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES)) i_array (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_go), .wr_en(wr_go), .addr(mem_addr),
    .wdata(mem_wdata), .fill(erase_ok), .mark_bad(erase_fail), .tgt_sector(erase_sector),
    .rdata(mem_rdata), .suspect(sector_suspect)
  );

  AST_ABORT_REPORTS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && irq_req) |=> ctrl_rdata[3] && !ctrl_rdata[0]); // R6
  AST_BUSY_ON_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (erasing && mem_rd && addr_sector == erase_sector) |-> mem_busy); // R9
  AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> !$rose(ctrl_rdata[0])); // R10
endmodule

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
  localparam int EC = 8;
  localparam int LC = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_sel, irq_req, mem_rd, mem_wr;
  logic [7:0] reg_wdata, mem_wdata;
  logic [1:0] op_sector;
  logic [5:0] mem_addr;
  logic [7:0] ctrl_rdata, mem_rdata;
  logic       mem_busy, locked;
  logic [3:0] sector_suspect;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.SECTORS(4), .SECTOR_BYTES(16), .ERASE_CYCLES(EC), .LOCK_CYCLES(LC)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rdata(ctrl_rdata), .op_sector(op_sector), .irq_req(irq_req), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_busy(mem_busy), .locked(locked), .sector_suspect(sector_suspect)
  );

  // addr, program data, expected read-back (old AND data, starting from FFh)
  localparam logic [23:0] VEC [7] = '{
    {8'h00, 8'h3C, 8'h3C}, {8'h00, 8'hF0, 8'h30}, {8'h11, 8'hA5, 8'hA5},
    {8'h1F, 8'h00, 8'h00}, {8'h2A, 8'h7E, 8'h7E}, {8'h2A, 8'hE7, 8'h66},
    {8'h3F, 8'h81, 8'h81}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic prog(input logic [5:0] a, input logic [7:0] d);
    mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    tick();
    mem_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    mem_rd = 1'b1; mem_addr = a;
    tick();
    mem_rd = 1'b0;
    v = mem_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0; irq_req = 0; mem_rd = 0; mem_wr = 0;
    mem_addr = 0; mem_wdata = 0; op_sector = 0;
    do_reset();
    chk("R11 ctrl", ctrl_rdata, 8'h00);
    chk("R11 locked", {7'd0, locked}, 8'h00);
    chk("R11 suspect", {4'd0, sector_suspect}, 8'h00);
    rd(6'h09, v); chk("R11 array", v, 8'hFF);

    for (int i = 0; i < 7; i++) begin
      wreg(1'b1, 8'hA5);
      wreg(1'b0, 8'h50);
      prog(VEC[i][21:16], VEC[i][15:8]);
      rd(VEC[i][21:16], v);
      chk("R4 program AND", v, VEC[i][7:0]);
    end
    chk("R1 program code no start", ctrl_rdata, 8'h50);

    // R8: key wiped after a program; second program has no effect
    wreg(1'b1, 8'hA5); prog(6'h05, 8'h0F); prog(6'h05, 8'h00);
    rd(6'h05, v); chk("R8 key wiped after program", v, 8'h0F);
    // R7: wrong key blocks programming
    wreg(1'b1, 8'h5A); prog(6'h06, 8'h00);
    rd(6'h06, v); chk("R7 wrong key program", v, 8'hFF);

    // R3/R5/R9: erase sector 0
    wreg(1'b1, 8'hA5); op_sector = 2'd0; wreg(1'b0, 8'hA1);
    chk("R3 start set", ctrl_rdata, 8'hA1);
    mem_rd = 1'b1; mem_addr = 6'h03; #0.5;
    chk("R9 busy same sector", {7'd0, mem_busy}, 8'h01);
    mem_addr = 6'h11; #0.5;
    chk("R9 idle other sector", {7'd0, mem_busy}, 8'h00);
    mem_rd = 1'b0;
    wreg(1'b0, 8'h50);
    chk("R2 write ignored while running", ctrl_rdata, 8'hA1);
    repeat (EC - 2) tick();
    chk("R3 start still set", {7'd0, ctrl_rdata[0]}, 8'h01);
    tick();
    chk("R3 start cleared", ctrl_rdata, 8'hA0);
    rd(6'h00, v); chk("R5 sector filled", v, 8'hFF);
    rd(6'h11, v); chk("R5 other sector kept", v, 8'hA5);
    wreg(1'b0, 8'h50); prog(6'h01, 8'h00);
    rd(6'h01, v); chk("R8 key wiped after erase", v, 8'hFF);

    // R6: abort erase of sector 1
    wreg(1'b1, 8'hA5); op_sector = 2'd1; wreg(1'b0, 8'hA1);
    repeat (2) tick();
    irq_req = 1'b1; tick(); irq_req = 1'b0;
    chk("R6 abort status", ctrl_rdata, 8'hA8);
    chk("R6 suspect", {4'd0, sector_suspect}, 8'h02);
    rd(6'h11, v); chk("R6 not filled", v, 8'hA5);
    wreg(1'b0, 8'h50); chk("R2 status read-only", ctrl_rdata, 8'h58);

    // R12: interrupt in the final erase cycle wins
    wreg(1'b1, 8'hA5); op_sector = 2'd2; wreg(1'b0, 8'hA1);
    repeat (EC - 1) tick();
    irq_req = 1'b1; tick(); irq_req = 1'b0;
    chk("R12 abort wins", ctrl_rdata, 8'hA8);
    rd(6'h2A, v); chk("R12 not filled", v, 8'h66);

    // R5: clean erase of sector 1 clears its flag
    wreg(1'b1, 8'hA5); op_sector = 2'd1; wreg(1'b0, 8'hA1);
    repeat (EC) tick();
    chk("R5 status ok", ctrl_rdata, 8'hA0);
    chk("R5 flag cleared", {4'd0, sector_suspect}, 8'h04);

    // R1 / R7: invalid code and missing key
    wreg(1'b1, 8'hA5); wreg(1'b0, 8'h31); tick();
    chk("R1 invalid code", ctrl_rdata, 8'h30);
    wreg(1'b1, 8'h5A); wreg(1'b0, 8'hA1); tick();
    chk("R7 wrong key erase", ctrl_rdata, 8'hA0);

    // R10: lock
    wreg(1'b1, 8'hA5); wreg(1'b0, 8'h61);
    mem_rd = 1'b1; mem_addr = 6'h3F; #0.5;
    chk("R9 busy during lock", {7'd0, mem_busy}, 8'h01);
    mem_rd = 1'b0;
    repeat (LC - 1) tick();
    chk("R10 not yet locked", {7'd0, locked}, 8'h00);
    tick();
    chk("R10 locked", {7'd0, locked}, 8'h01);
    chk("R3 lock start cleared", ctrl_rdata, 8'h60);
    wreg(1'b1, 8'hA5); op_sector = 2'd0; wreg(1'b0, 8'hA1); tick();
    chk("R10 erase ignored", ctrl_rdata, 8'hA0);
    wreg(1'b0, 8'h50); prog(6'h3F, 8'h00);
    rd(6'h3F, v); chk("R10 program ignored", v, 8'h81);
    chk("R10 stays locked", {7'd0, locked}, 8'h01);

    do_reset();
    chk("R11 ctrl after reset", ctrl_rdata, 8'h00);
    chk("R11 unlocked after reset", {7'd0, locked}, 8'h00);
    rd(6'h3F, v); chk("R11 array after reset", v, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule